// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles even parity for a 32-bit multiplexed address/data bus that carries a 4-bit command/byte-enable field next to it. Every clock it computes a parity bit over all 36 bits on the bus and registers it. The registered bit leaves the block one clock later, together with an output enable. The enable is raised only when the unit owns the bus for that phase. For an address phase, that means it is the initiator. For a data phase, it means it is either the initiator of a write or the target of a read.

When the unit is the target of a write, it compares the parity of each completed data phase with the parity bit the initiator returns one clock later. A data phase is complete when both ready strobes are low. A mismatch pulses the active-low error output and sets a sticky status bit. It also sets an interrupt-pending bit, which can raise one of two interrupt requests depending on configuration. An external device that reports a parity error on its own error line sets the interrupt-pending bit as well.

The checker is a two-state machine. It starts in `CK_IDLE`, which means nothing is awaiting comparison. Transition `capture` (completed target-write data phase) leads from either state to `CK_PEND`, which means the expected parity is held for a compare on the next clock. Transition `drain` (no new capture) leads from either state back to `CK_IDLE`. The compare is made in every clock spent in `CK_PEND`.

Top module: `pci_parity_unit`

## Requirements
- R1: `par_out` equals, one clock later, the XOR of all 32 `ad_in` bits and all 4 `cbe_in` bits, whatever the byte enables hold. This makes the count of ones across the 36 bits plus parity even.
- R2: `par_oe` is high in the clock after a clock where `ad_oe` was high and the unit was entitled to drive. It is entitled when `addr_phase`=1 and `is_initiator`=1, or when `addr_phase`=0 and `is_initiator`==`is_write` (initiator write or target read). Otherwise `par_oe` is low.
- R3: A data phase is captured for checking only at an edge with `addr_phase`=0, `is_initiator`=0, `is_write`=1, `irdy_n`=0 and `trdy_n`=0.
- R4: When a phase was captured at edge N and `par_in` at edge N+1 differs from the parity of that phase, `perr_out_n` is low for exactly the clock after edge N+1. In every other clock it is high.
- R5: `par_err_stat` is set at the same edge `perr_out_n` falls and stays set until an edge with `stat_clr`=1. If a new error arrives at the clearing edge, the set wins.
- R6: An edge sampling `perr_in_n`=0 sets the interrupt-pending state but not `par_err_stat`. An internal mismatch sets both. `stat_clr` clears the interrupt-pending state, with set winning.
- R7: `nmi_req` = pending & `nmi_en`. `smi_req` = pending & `smi_en` & !`nmi_en`. Both are never high together.
- R8: While `rst_n`=0, `par_out`, `par_oe`, `par_err_stat`, `nmi_req` and `smi_req` are 0, `perr_out_n` is 1 and the checker is in `CK_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ad_in | input | 32 | Address/data value on the bus this clock |
| cbe_in | input | 4 | Command/byte-enable value on the bus this clock |
| ad_oe | input | 1 | Unit drives the address/data lines this clock |
| addr_phase | input | 1 | This clock is an address phase |
| is_initiator | input | 1 | Unit is initiator (1) or target (0) |
| is_write | input | 1 | Current transaction is a write |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready, active low |
| par_in | input | 1 | Parity bit sampled from the bus |
| perr_in_n | input | 1 | Parity error reported by another device, active low |
| nmi_en | input | 1 | Route errors to the non-maskable request |
| smi_en | input | 1 | Route errors to the management request |
| stat_clr | input | 1 | Write-one-to-clear of the status bits |
| par_out | output | 1 | Registered parity bit |
| par_oe | output | 1 | Output enable for the parity bit |
| perr_out_n | output | 1 | Detected parity error, active low |
| par_err_stat | output | 1 | Sticky detected-error status |
| nmi_req | output | 1 | Non-maskable interrupt request |
| smi_req | output | 1 | Management interrupt request |

## Verification
Several properties are checked on every clock. The one-clock parity delay and the registered enable rule are checked this way. So are two facts about any error pulse: it is always preceded, two clocks back, by a completed target-write data phase, and it coincides with the status bit rising. The sticky hold of the status bit and the exclusion between the two interrupt requests are also checked every clock. Only the bench scenarios can show the remaining behaviours. These are that a wrong parity bit actually produces the pulse, that a correct one does not, and that phases with a ready strobe high or the wrong role are never checked. The bench also shows that an external error reaches the interrupts without touching the status, and how a clear interacts with a new error arriving in the same clock.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

    typedef enum logic [0:0] {
        CK_IDLE = 1'b0,
        CK_PEND = 1'b1
    } chk_state_t;

endpackage

// File: rtl/pci_par_gen.sv
module pci_par_gen #(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_in,
    input  logic [CBE_W-1:0] cbe_in,
    input  logic             ad_oe,
    input  logic             addr_phase,
    input  logic             is_initiator,
    input  logic             is_write,
    output logic             par_now,
    output logic             par_out,
    output logic             par_oe
);
    localparam int LANE_W = 8;
    localparam int N_LANE = (AD_W + LANE_W - 1) / LANE_W;
    localparam int PAD_W  = N_LANE * LANE_W;

    logic [PAD_W-1:0]  ad_pad;
    logic [N_LANE-1:0] lane_par;
    logic              drive_ok;

    assign ad_pad = PAD_W'(ad_in);

    // one parity bit per byte lane, then fold the lanes and the command bits
    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        assign lane_par[g] = ^ad_pad[g*LANE_W +: LANE_W];
    end

    assign par_now = (^lane_par) ^ (^cbe_in);

    always_comb begin
        unique case (addr_phase)
            1'b1:    drive_ok = is_initiator;
            default: drive_ok = (is_initiator == is_write);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_out <= 1'b0;
            par_oe  <= 1'b0;
        end else begin
            par_out <= par_now;
            par_oe  <= ad_oe && drive_ok;
        end
    end
endmodule

// File: rtl/pci_par_chk.sv
module pci_par_chk
    import pci_par_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic par_now,
    input  logic addr_phase,
    input  logic is_initiator,
    input  logic is_write,
    input  logic irdy_n,
    input  logic trdy_n,
    input  logic par_in,
    output logic err_evt,
    output logic perr_out_n
);
    chk_state_t state_q, state_d;
    logic       exp_q;
    logic       capture;

    assign capture = !addr_phase && !is_initiator && is_write && !irdy_n && !trdy_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CK_IDLE;
            exp_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (capture) exp_q <= par_now;
        end
    end

    // next state: capture / drain
    always_comb begin
        unique case (state_q)
            CK_IDLE: state_d = capture ? CK_PEND : CK_IDLE;
            CK_PEND: state_d = capture ? CK_PEND : CK_IDLE;
            default: state_d = CK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CK_PEND: err_evt = (par_in != exp_q);
            default: err_evt = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) perr_out_n <= 1'b1;
        else        perr_out_n <= !err_evt;
    end
endmodule

// File: rtl/pci_par_report.sv
module pci_par_report (
    input  logic clk,
    input  logic rst_n,
    input  logic err_evt,
    input  logic perr_in_n,
    input  logic stat_clr,
    input  logic nmi_en,
    input  logic smi_en,
    output logic par_err_stat,
    output logic nmi_req,
    output logic smi_req
);
    logic irq_pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_err_stat <= 1'b0;
            irq_pend_q   <= 1'b0;
        end else begin
            par_err_stat <= (par_err_stat && !stat_clr) || err_evt;
            irq_pend_q   <= (irq_pend_q && !stat_clr) || err_evt || !perr_in_n;
        end
    end

    assign nmi_req = irq_pend_q && nmi_en;
    assign smi_req = irq_pend_q && smi_en && !nmi_en;
endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit #(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_in,
    input  logic [CBE_W-1:0] cbe_in,
    input  logic             ad_oe,
    input  logic             addr_phase,
    input  logic             is_initiator,
    input  logic             is_write,
    input  logic             irdy_n,
    input  logic             trdy_n,
    input  logic             par_in,
    input  logic             perr_in_n,
    input  logic             nmi_en,
    input  logic             smi_en,
    input  logic             stat_clr,
    output logic             par_out,
    output logic             par_oe,
    output logic             perr_out_n,
    output logic             par_err_stat,
    output logic             nmi_req,
    output logic             smi_req
);
    logic par_now;
    logic err_evt;

    pci_par_gen #(.AD_W(AD_W), .CBE_W(CBE_W)) u_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .ad_in        (ad_in),
        .cbe_in       (cbe_in),
        .ad_oe        (ad_oe),
        .addr_phase   (addr_phase),
        .is_initiator (is_initiator),
        .is_write     (is_write),
        .par_now      (par_now),
        .par_out      (par_out),
        .par_oe       (par_oe)
    );

    pci_par_chk u_chk (
        .clk          (clk),
        .rst_n        (rst_n),
        .par_now      (par_now),
        .addr_phase   (addr_phase),
        .is_initiator (is_initiator),
        .is_write     (is_write),
        .irdy_n       (irdy_n),
        .trdy_n       (trdy_n),
        .par_in       (par_in),
        .err_evt      (err_evt),
        .perr_out_n   (perr_out_n)
    );

    pci_par_report u_rep (
        .clk          (clk),
        .rst_n        (rst_n),
        .err_evt      (err_evt),
        .perr_in_n    (perr_in_n),
        .stat_clr     (stat_clr),
        .nmi_en       (nmi_en),
        .smi_en       (smi_en),
        .par_err_stat (par_err_stat),
        .nmi_req      (nmi_req),
        .smi_req      (smi_req)
    );
endmodule

// File: rtl/pci_parity_unit_chk.sv
module pci_parity_unit_chk #(
    parameter int AD_W  = 32,
    parameter int CBE_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AD_W-1:0]  ad_in,
    input logic [CBE_W-1:0] cbe_in,
    input logic             ad_oe,
    input logic             addr_phase,
    input logic             is_initiator,
    input logic             is_write,
    input logic             irdy_n,
    input logic             trdy_n,
    input logic             stat_clr,
    input logic             par_out,
    input logic             par_oe,
    input logic             perr_out_n,
    input logic             par_err_stat,
    input logic             nmi_req,
    input logic             smi_req
);
    // R1
    par_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_out == $past(^{ad_in, cbe_in}));

    // R2
    par_oe_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe == $past(ad_oe && (addr_phase ? is_initiator : (is_initiator == is_write))));

    // R3
    perr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !perr_out_n |-> $past(!addr_phase && !is_initiator && is_write && !irdy_n && !trdy_n, 2));

    // R4
    perr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(perr_out_n) |-> $rose(par_err_stat) || $past(par_err_stat));

    // R5
    stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(par_err_stat) && !$past(stat_clr) |-> par_err_stat);

    // R5
    stat_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_err_stat) |-> !perr_out_n);

    // R7
    irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nmi_req, smi_req}));
endmodule

bind pci_parity_unit pci_parity_unit_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_prop (
    .clk          (clk),
    .rst_n        (rst_n),
    .ad_in        (ad_in),
    .cbe_in       (cbe_in),
    .ad_oe        (ad_oe),
    .addr_phase   (addr_phase),
    .is_initiator (is_initiator),
    .is_write     (is_write),
    .irdy_n       (irdy_n),
    .trdy_n       (trdy_n),
    .stat_clr     (stat_clr),
    .par_out      (par_out),
    .par_oe       (par_oe),
    .perr_out_n   (perr_out_n),
    .par_err_stat (par_err_stat),
    .nmi_req      (nmi_req),
    .smi_req      (smi_req)
);

// File: tb/pci_parity_unit_tb.sv
`timescale 1ns/1ps
module pci_parity_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ad_in = '0;
    logic [3:0]  cbe_in = '0;
    logic        ad_oe = 1'b0, addr_phase = 1'b0, is_initiator = 1'b0, is_write = 1'b0;
    logic        irdy_n = 1'b1, trdy_n = 1'b1, par_in = 1'b0, perr_in_n = 1'b1;
    logic        nmi_en = 1'b0, smi_en = 1'b0, stat_clr = 1'b0;
    logic        par_out, par_oe, perr_out_n, par_err_stat, nmi_req, smi_req;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // reference state
    logic m_par = 1'b0, m_oe = 1'b0, m_perr_n = 1'b1, m_stat = 1'b0, m_irq = 1'b0;
    logic m_pend = 1'b0, m_exp = 1'b0, last_par = 1'b0;

    always #4 clk = ~clk;

    pci_parity_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ad_in(ad_in), .cbe_in(cbe_in), .ad_oe(ad_oe),
        .addr_phase(addr_phase), .is_initiator(is_initiator), .is_write(is_write),
        .irdy_n(irdy_n), .trdy_n(trdy_n), .par_in(par_in), .perr_in_n(perr_in_n),
        .nmi_en(nmi_en), .smi_en(smi_en), .stat_clr(stat_clr),
        .par_out(par_out), .par_oe(par_oe), .perr_out_n(perr_out_n),
        .par_err_stat(par_err_stat), .nmi_req(nmi_req), .smi_req(smi_req)
    );

    function automatic logic even_par(input logic [31:0] a, input logic [3:0] c);
        logic p = 1'b0;
        for (int i = 0; i < 32; i++) p ^= a[i];
        for (int i = 0; i < 4; i++)  p ^= c[i];
        return p;
    endfunction

    function automatic logic may_drive(input logic ap, input logic ini, input logic wr);
        if (ap) return ini;
        return (ini && wr) || (!ini && !wr);
    endfunction

    task automatic check(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // advance the reference over one edge using inputs held across it
    task automatic model_step();
        logic mism;
        logic cap;
        mism = m_pend && (par_in != m_exp);
        cap  = !addr_phase && !is_initiator && is_write && !irdy_n && !trdy_n;
        m_par    = even_par(ad_in, cbe_in);
        m_oe     = ad_oe && may_drive(addr_phase, is_initiator, is_write);
        m_perr_n = !mism;
        m_stat   = (m_stat && !stat_clr) || mism;
        m_irq    = (m_irq && !stat_clr) || mism || !perr_in_n;
        if (cap) m_exp = m_par;
        m_pend   = cap;
    endtask

    task automatic check_all();
        check("R1 par_out", par_out, m_par);
        check("R2 par_oe", par_oe, m_oe);
        check("R4 perr_out_n", perr_out_n, m_perr_n);
        check("R5 par_err_stat", par_err_stat, m_stat);
        check("R7 nmi_req", nmi_req, m_irq && nmi_en);
        check("R7 smi_req", smi_req, m_irq && smi_en && !nmi_en);
    endtask

    task automatic cycle();
        @(posedge clk);
        #1;
        model_step();
        last_par = m_par;
        check_all();
    endtask

    // target write data phase, parity returned with optional flip
    task automatic tgt_write(input logic [31:0] a, input logic [3:0] c, input logic flip);
        @(negedge clk);
        ad_in = a; cbe_in = c; addr_phase = 0; is_initiator = 0; is_write = 1;
        irdy_n = 0; trdy_n = 0; ad_oe = 0; stat_clr = 0; perr_in_n = 1;
        cycle();
        @(negedge clk);
        irdy_n = 1; trdy_n = 1;
        par_in = even_par(a, c) ^ flip;
        cycle();
        @(negedge clk);
        cycle();
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(posedge clk);
        #1;
        // R8 reset state
        check("R8 par_out", par_out, 1'b0);
        check("R8 par_oe", par_oe, 1'b0);
        check("R8 perr_out_n", perr_out_n, 1'b1);
        check("R8 par_err_stat", par_err_stat, 1'b0);
        check("R8 nmi_req", nmi_req, 1'b0);
        check("R8 smi_req", smi_req, 1'b0);
        @(negedge clk);
        rst_n = 1;

        // R4 R5: directed error, byte enables all off still counted (R1)
        nmi_en = 1;
        tgt_write(32'hFFFF_0001, 4'hF, 1'b1);
        check("R5 sticky after error", par_err_stat, 1'b1);
        check("R7 nmi after error", nmi_req, 1'b1);
        // R5 clear
        @(negedge clk); stat_clr = 1; cycle();
        @(negedge clk); stat_clr = 0; cycle();
        check("R5 cleared", par_err_stat, 1'b0);
        // R4 correct parity: no error
        tgt_write(32'h1234_5678, 4'h0, 1'b0);
        check("R4 good parity no perr", par_err_stat, 1'b0);
        // R3 phase not completed: wrong parity ignored
        @(negedge clk);
        addr_phase = 0; is_initiator = 0; is_write = 1; irdy_n = 0; trdy_n = 1;
        cycle();
        @(negedge clk); par_in = ~last_par; irdy_n = 1; cycle();
        @(negedge clk); cycle();
        check("R3 incomplete ignored", par_err_stat, 1'b0);
        // R6 external error sets pending only; smi routing
        @(negedge clk); nmi_en = 0; smi_en = 1; perr_in_n = 0; cycle();
        @(negedge clk); perr_in_n = 1; cycle();
        check("R6 ext no status", par_err_stat, 1'b0);
        check("R6 ext smi", smi_req, 1'b1);
        @(negedge clk); stat_clr = 1; cycle();
        @(negedge clk); stat_clr = 0; cycle();

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            ad_in        = $urandom;
            cbe_in       = 4'($urandom);
            ad_oe        = 1'($urandom);
            addr_phase   = ($urandom % 8) == 0;
            is_initiator = 1'($urandom);
            is_write     = ($urandom % 4) != 0;
            irdy_n       = ($urandom % 3) == 0;
            trdy_n       = ($urandom % 3) == 0;
            par_in       = last_par ^ (($urandom % 4) == 0);
            perr_in_n    = ($urandom % 32) != 0;
            stat_clr     = ($urandom % 16) == 0;
            nmi_en       = 1'($urandom);
            smi_en       = 1'($urandom);
            cycle();
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule